// File: doc/BRIEF.md
# Blink and Heartbeat Duty Modulator

This block decides, for a single PWM channel, which duty-cycle value the comparator downstream should use in each PWM period. It takes two programmed duty levels, A and B, and two 16-bit timing parameters, X and Y. A cycle-start strobe from the channel's timebase marks the start of each PWM period. The block's internal counters move only on that strobe.

When modulation is off, the block passes A straight through. In plain blink mode it holds A for X+1 periods and then B for Y+1 periods, and repeats. In heartbeat mode the same two parameters mean something else: every X+1 periods the duty moves by Y+1 units from A toward B. It lands exactly on the far end, turns around, and walks back to A the same way. This gives a triangular ramp. Clearing the modulation enable returns all internal state to its starting point.

Top module: `pwm_duty_shaper`

## Requirements
- R1: While `blink_en` is 0, `duty_out` equals `duty_a` in the same cycle, whatever the strobe, mode and parameter inputs do.
- R2: With `blink_en`=1 and `ramp_en`=0, `duty_out` starts at A, switches to B on the edge that takes the (X+1)-th strobe, returns to A on the edge that takes the (Y+1)-th strobe after that, and repeats.
- R3: With `blink_en`=1 and `ramp_en`=1, `duty_out` starts at A and changes by Y+1 on every (X+1)-th strobe.
- R4: On the way out, the ramp counts upward when B > A and downward when B < A; on the way back it moves the opposite way.
- R5: A ramp step that would reach or pass its end point lands exactly on that end point (B going out, A coming back) and reverses direction for the next step.
- R6: The internal state changes only on a clock edge that samples `cycle_start`=1; with A, B and the mode inputs held, `duty_out` does not change on any other edge.
- R7: Any edge that samples `blink_en`=0 clears the pulse count, the blink level and the ramp position, so the next enabled run starts at A with a fresh count.
- R8: When A equals B, `duty_out` equals A in every mode.
- R9: A synchronous active-low reset puts the block in the same cleared state as R7.
- R10: The full 16-bit range of X and Y is honoured: Y=0xFFFF gives a step of 0x10000, which always clamps to the end point without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cycle_start | input | 1 | One-cycle strobe at the start of each PWM period |
| blink_en | input | 1 | Enables modulation; 0 forces A and clears state |
| ramp_en | input | 1 | 1 selects the triangular ramp, 0 selects two-level blink |
| duty_a | input | 16 | Base duty level A |
| duty_b | input | 16 | Alternate or ramp end duty level B |
| hold_x | input | 16 | Period count minus one per level (blink) or per step (ramp) |
| step_y | input | 16 | Period count minus one for B (blink) or step size minus one (ramp) |
| duty_out | output | 16 | Effective duty cycle for the current PWM period |

## Verification
The hardest case to reach is a turnaround where the step does not divide the span between A and B. Here the last step has to be shortened to land on the end point, and the next step has to leave in the opposite direction. The stimulus reaches this by choosing A, B and Y so that the span is not a multiple of Y+1, and by doing so in both ramp directions. A second run sets Y to its maximum, so that a single step exceeds the 16-bit range. A behavioural model of the ramp, with its own turnaround rule, is compared with the output on every clock, and hand-computed values are checked at each turnaround.

// File: rtl/pds_pkg.sv
// Shared types for the duty modulator.
package pds_pkg;

    // Which programmed level the two-level blink is currently showing.
    typedef enum logic {
        LVL_BASE = 1'b0,
        LVL_ALT  = 1'b1
    } blink_lvl_e;

    // Which end point the ramp is currently heading to.
    typedef enum logic {
        DIR_OUT  = 1'b0,
        DIR_BACK = 1'b1
    } ramp_dir_e;

endpackage

// File: rtl/pds_stride_counter.sv
// Counts strobes up to a programmable limit and flags the strobe that
// completes the interval (limit+1 strobes). Assumes limit is held steady
// while counting; clear wins over tick.
module pds_stride_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         wrap
);

    logic [W-1:0] cnt_q;

    // Interval completes on the strobe that finds the count at the limit.
    always_comb begin
        wrap = tick && (cnt_q == limit);
    end

    // Strobe counter: restarts on wrap, clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= wrap ? '0 : cnt_q + W'(1);
        end
    end

endmodule

// File: rtl/pds_blink_seq.sv
// Two-level blink state: toggles between the base and the alternate level
// each time an interval completes. Assumes flip is a single-cycle pulse.
module pds_blink_seq
    import pds_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       flip,
    output blink_lvl_e level
);

    blink_lvl_e lvl_q;

    // Level register: starts at the base level and toggles per interval.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            lvl_q <= LVL_BASE;
        end else if (flip) begin
            lvl_q <= (lvl_q == LVL_BASE) ? LVL_ALT : LVL_BASE;
        end
    end

    assign level = lvl_q;

endmodule

// File: rtl/pds_ramp_gen.sv
// Triangular ramp between a start and an end value. Each advance moves the
// position by step_m1+1 toward the current end point; a move that would
// reach or pass it lands on it exactly and turns the ramp around. The step
// is one bit wider than the values, so a full-range step never wraps.
// Assumes start/end values are steady while advancing.
module pds_ramp_gen
    import pds_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         advance,
    input  logic [W-1:0] start_val,
    input  logic [W-1:0] end_val,
    input  logic [W-1:0] step_m1,
    output logic [W-1:0] level
);

    localparam int SW = W + 1;

    logic [W-1:0]  pos_q;
    ramp_dir_e     dir_q;
    logic [W-1:0]  target;
    logic [W-1:0]  gap;
    logic [SW-1:0] step;
    logic          rising;
    logic          landing;
    logic [W-1:0]  moved;

    // Step geometry: aim, distance left, and the un-clamped next position.
    always_comb begin
        target  = (dir_q == DIR_OUT) ? end_val : start_val;
        rising  = (target >= pos_q);
        gap     = rising ? (target - pos_q) : (pos_q - target);
        step    = {1'b0, step_m1} + SW'(1);
        landing = ({1'b0, gap} <= step);
        moved   = rising ? (pos_q + step[W-1:0]) : (pos_q - step[W-1:0]);
    end

    // Position and direction: reload to start, else step or land and turn.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pos_q <= start_val;
            dir_q <= DIR_OUT;
        end else if (advance) begin
            if (landing) begin
                pos_q <= target;
                dir_q <= (dir_q == DIR_OUT) ? DIR_BACK : DIR_OUT;
            end else begin
                pos_q <= moved;
            end
        end
    end

    assign level = pos_q;

endmodule

// File: rtl/pwm_duty_shaper.sv
// Effective duty-cycle selector for one PWM channel: pass-through, two-level
// blink, or triangular heartbeat ramp. One strobe counter serves both modes;
// its limit is picked from hold_x/step_y by mode and blink level.
// Assumes cycle_start is a single-cycle pulse per PWM period.
module pwm_duty_shaper
    import pds_pkg::*;
#(
    parameter int DUTY_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cycle_start,
    input  logic              blink_en,
    input  logic              ramp_en,
    input  logic [DUTY_W-1:0] duty_a,
    input  logic [DUTY_W-1:0] duty_b,
    input  logic [CNT_W-1:0]  hold_x,
    input  logic [DUTY_W-1:0] step_y,
    output logic [DUTY_W-1:0] duty_out
);

    logic [CNT_W-1:0]  limit;
    logic              wrap;
    logic              ramp_active;
    blink_lvl_e        blink_lvl;
    logic [DUTY_W-1:0] ramp_lvl;

    // Mode decode and per-interval limit selection.
    always_comb begin
        ramp_active = blink_en && ramp_en;
        if (ramp_en || blink_lvl == LVL_BASE) begin
            limit = hold_x;
        end else begin
            limit = CNT_W'(step_y);
        end
    end

    pds_stride_counter #(.W(CNT_W)) u_stride (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!blink_en),
        .tick  (cycle_start),
        .limit (limit),
        .wrap  (wrap)
    );

    pds_blink_seq u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!blink_en),
        .flip  (wrap && !ramp_en),
        .level (blink_lvl)
    );

    pds_ramp_gen #(.W(DUTY_W)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!ramp_active),
        .advance   (wrap && ramp_en),
        .start_val (duty_a),
        .end_val   (duty_b),
        .step_m1   (step_y),
        .level     (ramp_lvl)
    );

    // Output select: base level when idle, else the active mode's level.
    always_comb begin
        if (!blink_en) begin
            duty_out = duty_a;
        end else if (ramp_en) begin
            duty_out = ramp_lvl;
        end else begin
            duty_out = (blink_lvl == LVL_ALT) ? duty_b : duty_a;
        end
    end

endmodule

// File: rtl/pds_checker.sv
// Port-level temporal checks for pwm_duty_shaper, attached by bind.
module pds_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cycle_start,
    input logic         blink_en,
    input logic         ramp_en,
    input logic [W-1:0] duty_a,
    input logic [W-1:0] duty_b,
    input logic [W-1:0] duty_out
);

    // R6: no strobe at the previous edge and steady inputs -> output steady.
    a_r6_quiet_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && blink_en && $past(blink_en) && !$past(cycle_start)
         && $stable(ramp_en) && $stable(duty_a) && $stable(duty_b))
        |-> $stable(duty_out));

    // R2: plain blink only ever shows one of the two programmed levels.
    a_r2_two_levels: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_en && !ramp_en) |-> (duty_out == duty_a || duty_out == duty_b));

    // R5: a steady ramp never leaves the span between A and B.
    a_r5_within_span: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_en && ramp_en && $past(blink_en && ramp_en)
         && $stable(duty_a) && $stable(duty_b))
        |-> ((duty_out >= ((duty_a < duty_b) ? duty_a : duty_b))
          && (duty_out <= ((duty_a < duty_b) ? duty_b : duty_a))));

    // R7: first cycle after modulation is enabled shows A.
    a_r7_restart_at_a: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && blink_en && !$past(blink_en) && $stable(duty_a))
        |-> (duty_out == duty_a));

    // R8: equal levels held across an enabled stretch give A.
    a_r8_equal_levels: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_en && $past(blink_en) && duty_a == duty_b
         && $stable(duty_a) && $stable(duty_b))
        |-> (duty_out == duty_a));

endmodule

bind pwm_duty_shaper pds_checker #(.W(DUTY_W)) u_pds_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycle_start (cycle_start),
    .blink_en    (blink_en),
    .ramp_en     (ramp_en),
    .duty_a      (duty_a),
    .duty_b      (duty_b),
    .duty_out    (duty_out)
);

// File: tb/sim_pwm_duty_shaper.sv
module sim_pwm_duty_shaper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cycle_start = 1'b0;
    logic        blink_en = 1'b0;
    logic        ramp_en = 1'b0;
    logic [15:0] duty_a = 16'h0;
    logic [15:0] duty_b = 16'h0;
    logic [15:0] hold_x = 16'h0;
    logic [15:0] step_y = 16'h0;
    logic [15:0] duty_out;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    string phase_tag = "R9";
    bit done = 1'b0;

    // reference model state
    int m_cnt, m_lvl, m_pos, m_dir;
    bit m_valid = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    pwm_duty_shaper u0 (
        .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
        .blink_en(blink_en), .ramp_en(ramp_en),
        .duty_a(duty_a), .duty_b(duty_b), .hold_x(hold_x), .step_y(step_y),
        .duty_out(duty_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: duty_out actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    function automatic int model_out();
        if (!blink_en) return int'(duty_a);
        if (ramp_en) return m_pos;
        return (m_lvl != 0) ? int'(duty_b) : int'(duty_a);
    endfunction

    // Behavioural reference: updated on every edge from the sampled inputs.
    always @(posedge clk) begin
        int lim, tgt, rem, stp;
        m_valid <= 1'b1;
        if (!rst_n || !blink_en) begin
            m_cnt = 0; m_lvl = 0; m_pos = int'(duty_a); m_dir = 0;
        end else begin
            if (!ramp_en) begin
                m_pos = int'(duty_a); m_dir = 0;
            end
            if (cycle_start) begin
                lim = ramp_en ? int'(hold_x) : ((m_lvl != 0) ? int'(step_y) : int'(hold_x));
                if (m_cnt == lim) begin
                    m_cnt = 0;
                    if (!ramp_en) begin
                        m_lvl = 1 - m_lvl;
                    end else begin
                        tgt = (m_dir == 0) ? int'(duty_b) : int'(duty_a);
                        stp = int'(step_y) + 1;
                        rem = (tgt > m_pos) ? tgt - m_pos : m_pos - tgt;
                        if (rem <= stp) begin
                            m_pos = tgt; m_dir = 1 - m_dir;
                        end else if (tgt > m_pos) begin
                            m_pos = m_pos + stp;
                        end else begin
                            m_pos = m_pos - stp;
                        end
                    end
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
        end
    end

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (m_valid && !done) chk(phase_tag, int'(duty_out), model_out());
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic tick(input bit s);
        @(posedge clk); #1 cycle_start = s;
    endtask

    task automatic run(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            tick(1'b1);
            for (int j = 1; j < gap; j++) tick(1'b0);
        end
        tick(1'b0);
    endtask

    task automatic idle_off();
        @(posedge clk); #1 blink_en = 1'b0; cycle_start = 1'b0;
        tick(1'b0);
    endtask

    task automatic at_neg(input string req, input int exp);
        @(negedge clk); chk(req, int'(duty_out), exp);
    endtask

    initial begin
        // R9: reset with modulation requested
        blink_en = 1'b1; duty_a = 16'h1234; duty_b = 16'hABCD; hold_x = 16'd1;
        repeat (3) tick(1'b0);
        at_neg("R9", 16'h1234);
        @(posedge clk); #1 rst_n = 1'b1;
        run(1, 3);
        at_neg("R9", 16'h1234);
        run(1, 3);
        at_neg("R9", 16'hABCD);

        // R1: pass-through while disabled
        idle_off(); phase_tag = "R1";
        duty_a = 16'h4321; ramp_en = 1'b1;
        run(5, 2);
        at_neg("R1", 16'h4321);
        @(posedge clk); #1 duty_a = 16'h0005;
        at_neg("R1", 16'h0005);

        // R2: plain blink, X=2, Y=1
        phase_tag = "R2";
        @(posedge clk); #1 ramp_en = 1'b0; duty_a = 16'h1000; duty_b = 16'h8000;
        hold_x = 16'd2; step_y = 16'd1; blink_en = 1'b1;
        run(2, 4);
        at_neg("R2", 16'h1000);
        run(1, 4);
        at_neg("R2", 16'h8000);
        run(2, 4);
        at_neg("R2", 16'h1000);
        run(20, 3);

        // R7: clear mid-count restarts from A with a fresh count
        phase_tag = "R7";
        idle_off(); run(2, 4);
        @(posedge clk); #1 blink_en = 1'b1;
        run(2, 4);
        idle_off();
        @(posedge clk); #1 blink_en = 1'b1;
        at_neg("R7", 16'h1000);
        run(2, 4);
        at_neg("R7", 16'h1000);
        run(1, 4);
        at_neg("R7", 16'h8000);

        // R3/R4: upward ramp, X=1, step 0x400
        idle_off(); phase_tag = "R3";
        duty_a = 16'h1000; duty_b = 16'h2000; hold_x = 16'd1; step_y = 16'h03FF;
        ramp_en = 1'b1;
        @(posedge clk); #1 blink_en = 1'b1;
        at_neg("R3", 16'h1000);
        run(2, 3);
        at_neg("R4", 16'h1400);
        run(6, 3);
        at_neg("R3", 16'h2000);
        run(2, 3);
        at_neg("R4", 16'h1C00);
        run(30, 2);

        // R5/R4: downward ramp, uneven step 0x201
        idle_off(); phase_tag = "R5";
        duty_a = 16'h9000; duty_b = 16'h8800; hold_x = 16'd0; step_y = 16'h0200;
        @(posedge clk); #1 blink_en = 1'b1;
        run(1, 2);
        at_neg("R4", 16'h8DFF);
        run(3, 2);
        at_neg("R5", 16'h8800);
        run(1, 2);
        at_neg("R5", 16'h8A01);
        run(3, 2);
        at_neg("R5", 16'h9000);
        run(1, 2);
        at_neg("R5", 16'h8DFF);

        // R6: irregular and back-to-back strobes during a ramp
        phase_tag = "R6";
        hold_x = 16'd2;
        for (int i = 0; i < 300; i++) tick((i % 3 == 0) || (i % 7 == 0));
        tick(1'b0);

        // R10: full-range step, both ways, and a huge hold count
        idle_off(); phase_tag = "R10";
        duty_a = 16'h0100; duty_b = 16'hF000; hold_x = 16'd0; step_y = 16'hFFFF;
        @(posedge clk); #1 blink_en = 1'b1;
        run(1, 2);
        at_neg("R10", 16'hF000);
        run(1, 2);
        at_neg("R10", 16'h0100);
        idle_off();
        duty_a = 16'hFFFF; duty_b = 16'h0000;
        @(posedge clk); #1 blink_en = 1'b1;
        run(1, 2);
        at_neg("R10", 16'h0000);
        idle_off();
        ramp_en = 1'b0; hold_x = 16'hFFFF;
        @(posedge clk); #1 blink_en = 1'b1;
        run(10, 2);
        at_neg("R10", 16'hFFFF);

        // R8: equal levels in both modes
        idle_off(); phase_tag = "R8";
        duty_a = 16'h5555; duty_b = 16'h5555; hold_x = 16'd0; step_y = 16'd3;
        @(posedge clk); #1 blink_en = 1'b1;
        run(6, 2);
        at_neg("R8", 16'h5555);
        @(posedge clk); #1 ramp_en = 1'b1;
        run(6, 2);
        at_neg("R8", 16'h5555);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule